// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block is the control sequencer that an 8-bit processor core uses for every flow change that goes through the hardware stack. It covers start-up after reset, level-triggered maskable interrupts, edge-requested non-maskable interrupts, the software break, subroutine call and return, and return from interrupt. The stack sits in a fixed page of memory, page 1 by default, and is indexed by an 8-bit pointer. The sequencer owns that pointer, the 16-bit program counter and the 8-bit status register. It reaches memory through one byte-wide port that completes one access per clock, with read data returned in the same cycle.

Decode hands the sequencer one command at a time over a valid/ready channel. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the sequencer is idle, so a command that arrives during a sequence is back-pressured until that sequence ends. While `cmd_valid` is high and the command has not been taken, decode must hold the command fields steady. The instruction-boundary command is the point where interrupts are considered. `seq_done` pulses for one cycle when any command has finished.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is low, and again after it is released, the sequencer sets the stack pointer to 0xFF and the status register to 0x24 (bit 2, the interrupt mask, is set). It then reads 0xFFFC and 0xFFFD, loads the program counter from them low byte first, and only after that raises `cmd_ready`.
- R2: A push writes to address 0x0100 + SP and then decrements SP. A pop increments SP and then reads from 0x0100 + SP.
- R3: Interrupt entry takes exactly 7 bus cycles. The addresses are PC, PC, 0x0100+SP, 0x0100+SP-1, 0x0100+SP-2, vector, vector+1. The three writes carry the PC high byte, the PC low byte, and the status with bit 4 (break) cleared. Afterwards the mask bit 2 is set and the PC holds the vector contents, little-endian.
- R4: At a boundary command (code 0), a high `irq_lvl` has no effect while mask bit 2 is set. If no NMI is pending, the command finishes with no bus cycle, and the PC becomes `cmd_pc` with SP unchanged.
- R5: A one-cycle pulse on `nmi_req` is latched. The next boundary command services it through vector 0xFFFA/0xFFFB whatever the mask bit holds. Servicing clears the request, so the following boundary command does not enter again.
- R6: When an unmasked IRQ and a pending NMI meet at the same boundary, the IRQ is entered first, through 0xFFFE/0xFFFF. The NMI stays pending and is entered at the next boundary.
- R7: Break (code 1, `cmd_pc` = address after the opcode) pushes `cmd_pc`+1 and the status unchanged. It then sets bit 4, leaves the mask bit as it was, and loads the PC from 0xFFFE/0xFFFF.
- R8: Call (code 2) pushes `cmd_pc`, the address of the last byte of the call, high byte then low byte, in two bus cycles. It then sets the PC to `cmd_target`.
- R9: Return from subroutine (code 3) pops the low byte and then the high byte, and sets the PC to that address plus one, carrying into the high byte.
- R10: Return from interrupt (code 4) pops the status, then the PC low byte, then the high byte, and applies no increment.
- R11: `cmd_ready` stays low for every cycle of a sequence, and no memory access occurs while it is high. Codes 5 to 7 finish at once with `seq_done` and leave PC, SP and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 1 | Maskable interrupt request, level |
| nmi_req | input | 1 | Non-maskable request pulse, latched |
| cmd_valid | input | 1 | Command offered by decode |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_code | input | 3 | 0 boundary, 1 break, 2 call, 3 return, 4 return-from-interrupt |
| cmd_pc | input | 16 | PC value that goes with the command |
| cmd_target | input | 16 | Call destination |
| mem_addr | output | 16 | Bus address |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, same cycle |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status register |
| seq_done | output | 1 | One-cycle pulse when a command has finished |

## Verification
The hardest situation to reach is an IRQ and an NMI arriving at the same boundary while the mask is clear. The mask powers up set, and no port writes the status directly. The bench therefore overwrites the saved status byte in its memory model before a return-from-interrupt, which clears the mask. It then holds `irq_lvl` high and pulses `nmi_req` just before the boundary command. It also checks that the break bit is cleared in the pushed byte during an NMI that directly follows a break, while the bit stays set in the register.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam logic [2:0] CMD_BOUND = 3'd0;
  localparam logic [2:0] CMD_BRK   = 3'd1;
  localparam logic [2:0] CMD_CALL  = 3'd2;
  localparam logic [2:0] CMD_RTS   = 3'd3;
  localparam logic [2:0] CMD_RTI   = 3'd4;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;

  typedef enum logic [3:0] {
    S_RLO, S_RHI, S_IDLE, S_D1, S_D2, S_PH, S_PL, S_PP,
    S_VL, S_VH, S_POPP, S_POPL, S_POPH
  } state_e;

  typedef enum logic [2:0] {
    K_IRQ, K_NMI, K_BRK, K_CALL, K_RTS, K_RTI
  } kind_e;
endpackage

// File: rtl/isq_nmi_latch.sv
module isq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end

  // R5: a latched request survives until it is serviced
  p_nmi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o);
  p_nmi_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
endmodule

// File: rtl/isq_arbiter.sv
module isq_arbiter (
  input  logic bound_i,
  input  logic irq_i,
  input  logic mask_i,
  input  logic nmi_i,
  output logic take_irq_o,
  output logic take_nmi_o
);
  // IRQ is examined first, NMI only when no IRQ is taken
  always_comb begin
    take_irq_o = bound_i & irq_i & ~mask_i;
    take_nmi_o = bound_i & nmi_i & ~take_irq_o;
  end

  always_comb begin
    if (take_nmi_o) a_irq_first_r6: assert (!(irq_i && !mask_i));
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq #(
  parameter int DW = 8,
  parameter int AW = 2 * DW,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01,
  parameter logic [DW-1:0] SP_INIT = 8'hFF,
  parameter logic [DW-1:0] ST_INIT = 8'h24,
  parameter logic [AW-1:0] RST_VEC = 16'hFFFC,
  parameter logic [AW-1:0] NMI_VEC = 16'hFFFA,
  parameter logic [AW-1:0] IRQ_VEC = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_lvl,
  input  logic          nmi_req,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_code,
  input  logic [AW-1:0] cmd_pc,
  input  logic [AW-1:0] cmd_target,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] status_o,
  output logic          seq_done
);
  import isq_pkg::*;

  localparam logic [DW-1:0] I_MASK = DW'(1) << FLAG_I;
  localparam logic [DW-1:0] B_MASK = DW'(1) << FLAG_B;

  state_e        st_q;
  kind_e         kind_q;
  logic [AW-1:0] pc_q, hold_q, tgt_q, vec_base;
  logic [DW-1:0] sp_q, lo_q, flags_q, sp_inc;
  logic          done_q, acc, bound_acc, take_irq, take_nmi, nmi_pend;

  assign acc       = cmd_valid & cmd_ready;
  assign bound_acc = acc & (cmd_code == CMD_BOUND);
  assign cmd_ready = (st_q == S_IDLE);
  assign sp_inc    = sp_q + DW'(1);
  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign status_o  = flags_q;
  assign seq_done  = done_q;

  isq_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .set_i(nmi_req), .clr_i(take_nmi), .pend_o(nmi_pend)
  );

  isq_arbiter u_arb (
    .bound_i(bound_acc), .irq_i(irq_lvl), .mask_i(flags_q[FLAG_I]), .nmi_i(nmi_pend),
    .take_irq_o(take_irq), .take_nmi_o(take_nmi)
  );

  // bus drive, one access per state
  always_comb begin
    mem_addr  = '0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    vec_base  = (kind_q == K_NMI) ? NMI_VEC : IRQ_VEC;
    case (st_q)
      S_RLO: begin mem_addr = RST_VEC; mem_re = 1'b1; end
      S_RHI: begin mem_addr = RST_VEC + AW'(1); mem_re = 1'b1; end
      S_D1, S_D2: begin mem_addr = hold_q; mem_re = 1'b1; end
      S_PH: begin
        mem_addr = {STACK_PAGE, sp_q}; mem_we = 1'b1; mem_wdata = hold_q[AW-1:DW];
      end
      S_PL: begin
        mem_addr = {STACK_PAGE, sp_q}; mem_we = 1'b1; mem_wdata = hold_q[DW-1:0];
      end
      S_PP: begin
        mem_addr  = {STACK_PAGE, sp_q}; mem_we = 1'b1;
        mem_wdata = (kind_q == K_BRK) ? flags_q : (flags_q & ~B_MASK);
      end
      S_VL: begin mem_addr = vec_base; mem_re = 1'b1; end
      S_VH: begin mem_addr = vec_base + AW'(1); mem_re = 1'b1; end
      S_POPP, S_POPL, S_POPH: begin mem_addr = {STACK_PAGE, sp_inc}; mem_re = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_RLO;
      kind_q  <= K_IRQ;
      sp_q    <= SP_INIT;
      flags_q <= ST_INIT | I_MASK;
      pc_q    <= '0;
      hold_q  <= '0;
      tgt_q   <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_RLO: begin lo_q <= mem_rdata; st_q <= S_RHI; end
        S_RHI: begin pc_q <= {mem_rdata, lo_q}; st_q <= S_IDLE; end
        S_IDLE: if (acc) begin
          hold_q <= cmd_pc;
          case (cmd_code)
            CMD_BOUND: begin
              if (take_irq)      begin kind_q <= K_IRQ; st_q <= S_D1; end
              else if (take_nmi) begin kind_q <= K_NMI; st_q <= S_D1; end
              else begin pc_q <= cmd_pc; done_q <= 1'b1; end
            end
            CMD_BRK: begin
              kind_q <= K_BRK; hold_q <= cmd_pc + AW'(1); st_q <= S_D1;
            end
            CMD_CALL: begin kind_q <= K_CALL; tgt_q <= cmd_target; st_q <= S_PH; end
            CMD_RTS:  begin kind_q <= K_RTS; st_q <= S_POPL; end
            CMD_RTI:  begin kind_q <= K_RTI; st_q <= S_POPP; end
            default:  done_q <= 1'b1;
          endcase
        end
        S_D1: st_q <= S_D2;
        S_D2: st_q <= S_PH;
        S_PH: begin sp_q <= sp_q - DW'(1); st_q <= S_PL; end
        S_PL: begin
          sp_q <= sp_q - DW'(1);
          if (kind_q == K_CALL) begin
            pc_q <= tgt_q; done_q <= 1'b1; st_q <= S_IDLE;
          end else st_q <= S_PP;
        end
        S_PP: begin
          sp_q <= sp_q - DW'(1);
          if (kind_q == K_BRK) flags_q <= flags_q | B_MASK;
          else                 flags_q <= flags_q | I_MASK;
          st_q <= S_VL;
        end
        S_VL: begin lo_q <= mem_rdata; st_q <= S_VH; end
        S_VH: begin
          pc_q <= {mem_rdata, lo_q}; done_q <= 1'b1; st_q <= S_IDLE;
        end
        S_POPP: begin sp_q <= sp_inc; flags_q <= mem_rdata; st_q <= S_POPL; end
        S_POPL: begin sp_q <= sp_inc; lo_q <= mem_rdata; st_q <= S_POPH; end
        S_POPH: begin
          sp_q <= sp_inc;
          pc_q <= (kind_q == K_RTS) ? ({mem_rdata, lo_q} + AW'(1)) : {mem_rdata, lo_q};
          done_q <= 1'b1;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_q == $past(sp_q) - DW'(1)));
  p_pop_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {S_POPP, S_POPL, S_POPH}) |=> (sp_q == $past(sp_q) + DW'(1)));
  p_int_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PP && kind_q != K_BRK) |=> status_o[FLAG_I]);
  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_acc && flags_q[FLAG_I] && !nmi_pend) |=> (cmd_ready && seq_done));
  p_idle_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_we && !mem_re));
endmodule

// File: tb/tb_irq_stack_seq.sv
module tb_irq_stack_seq;
  logic clk = 1'b0, rst_n = 1'b0, irq_lvl = 1'b0, nmi_req = 1'b0, cmd_valid = 1'b0;
  logic cmd_ready, mem_re, mem_we, seq_done;
  logic [2:0] cmd_code = '0;
  logic [15:0] cmd_pc = '0, cmd_target = '0, mem_addr, pc_o;
  logic [7:0] mem_wdata, mem_rdata, sp_o, status_o;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  irq_stack_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .nmi_req(nmi_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_pc(cmd_pc), .cmd_target(cmd_target), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc_o(pc_o), .sp_o(sp_o), .status_o(status_o),
    .seq_done(seq_done)
  );

  // memory model: stack page stored, vectors fixed, other bytes derived from address
  logic [7:0] stk [256];
  logic       poke_en = 1'b0;
  logic [7:0] poke_a = '0, poke_v = '0;
  always_comb begin
    case (mem_addr)
      16'hFFFA: mem_rdata = 8'h00;
      16'hFFFB: mem_rdata = 8'h90;
      16'hFFFC: mem_rdata = 8'h00;
      16'hFFFD: mem_rdata = 8'h80;
      16'hFFFE: mem_rdata = 8'h00;
      16'hFFFF: mem_rdata = 8'hA0;
      default:  mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]]
                                                      : (mem_addr[7:0] ^ 8'h5A);
    endcase
  end
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) stk[i] <= 8'h00;
    end else if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    else if (poke_en) stk[poke_a] <= poke_v;
  end

  // bus trace and busy-cycle count, sampled mid-cycle
  logic [15:0] tr_a [16];
  logic        tr_w [16];
  logic [7:0]  tr_d [16];
  int tr_n = 0, busy = 0;
  always @(negedge clk) begin
    if (rst_n && (mem_re || mem_we) && tr_n < 16) begin
      tr_a[tr_n] = mem_addr; tr_w[tr_n] = mem_we; tr_d[tr_n] = mem_wdata; tr_n++;
    end
    if (rst_n && !cmd_ready) busy++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_cmd(input logic [2:0] code, input logic [15:0] pc, input logic [15:0] tgt,
                         input logic irq, input logic nmi, input logic [7:0] poke);
    @(negedge clk);
    irq_lvl = irq;
    if (poke != 8'h00) begin
      poke_a = sp_o + 8'd1; poke_v = poke; poke_en = 1'b1;
      @(negedge clk); poke_en = 1'b0;
    end
    if (nmi) begin
      nmi_req = 1'b1; @(negedge clk); nmi_req = 1'b0;
    end
    tr_n = 0; busy = 0;
    cmd_valid = 1'b1; cmd_code = code; cmd_pc = pc; cmd_target = tgt;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!seq_done) @(negedge clk);
    irq_lvl = 1'b0;
  endtask

  // code, pc, target, irq, nmi, stack poke, exp pc, exp sp, exp status, requirement
  localparam int NROW = 14;
  localparam logic [80:0] TBL [NROW] = '{
    {3'd0, 16'h8003, 16'h0000, 1'b1, 1'b0, 8'h00, 16'h8003, 8'hFF, 8'h24, 4'd4},  // R4
    {3'd2, 16'h8005, 16'h8100, 1'b0, 1'b0, 8'h00, 16'h8100, 8'hFD, 8'h24, 4'd8},  // R8
    {3'd3, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h00, 16'h8006, 8'hFF, 8'h24, 4'd9},  // R9
    {3'd1, 16'h8007, 16'h0000, 1'b0, 1'b0, 8'h00, 16'hA000, 8'hFC, 8'h34, 4'd7},  // R7
    {3'd4, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h20, 16'h8008, 8'hFF, 8'h20, 4'd10}, // R10
    {3'd0, 16'h8009, 16'h0000, 1'b1, 1'b0, 8'h00, 16'hA000, 8'hFC, 8'h24, 4'd3},  // R3
    {3'd0, 16'hA002, 16'h0000, 1'b1, 1'b1, 8'h00, 16'h9000, 8'hF9, 8'h24, 4'd5},  // R5
    {3'd0, 16'h9001, 16'h0000, 1'b0, 1'b0, 8'h00, 16'h9001, 8'hF9, 8'h24, 4'd5},  // R5
    {3'd4, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h00, 16'hA002, 8'hFC, 8'h24, 4'd10}, // R10
    {3'd4, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h00, 16'h8009, 8'hFF, 8'h20, 4'd10}, // R10
    {3'd0, 16'h800B, 16'h0000, 1'b1, 1'b1, 8'h00, 16'hA000, 8'hFC, 8'h24, 4'd6},  // R6
    {3'd0, 16'hA001, 16'h0000, 1'b1, 1'b0, 8'h00, 16'h9000, 8'hF9, 8'h24, 4'd6},  // R6
    {3'd2, 16'h12FF, 16'h4000, 1'b0, 1'b0, 8'h00, 16'h4000, 8'hF7, 8'h24, 4'd8},  // R8
    {3'd3, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h00, 16'h1300, 8'hF9, 8'h24, 4'd9}   // R9
  };

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    while (!cmd_ready) @(negedge clk);
    // R1: state after start-up
    chk("R1", "pc", pc_o, 16'h8000);
    chk("R1", "sp", sp_o, 8'hFF);
    chk("R1", "status", status_o, 8'h24);

    for (int r = 0; r < NROW; r++) begin
      logic [80:0] v;
      string tag;
      v = TBL[r];
      tag = $sformatf("R%0d row%0d", v[3:0], r);
      run_cmd(v[80:78], v[77:62], v[61:46], v[45], v[44], v[43:36]);
      chk(tag, "pc", pc_o, v[35:20]);
      chk(tag, "sp", sp_o, v[19:12]);
      chk(tag, "status", status_o, v[11:4]);
    end

    // R1: reset again mid-run, watch the vector fetch
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    tr_n = 0;
    @(posedge clk); #1 rst_n = 1'b1;
    while (!cmd_ready) @(negedge clk);
    chk("R1", "reset bus count", tr_n, 2);
    chk("R1", "reset addr0", tr_a[0], 16'hFFFC);
    chk("R1", "reset addr1", tr_a[1], 16'hFFFD);
    chk("R1", "pc", pc_o, 16'h8000);
    chk("R1", "sp", sp_o, 8'hFF);
    chk("R1", "status", status_o, 8'h24);

    // R7: break sets bit 4
    run_cmd(3'd1, 16'h8000, 16'h0000, 1'b0, 1'b0, 8'h00);
    chk("R7", "status", status_o, 8'h34);
    chk("R7", "pushed status", stk[8'hFD], 8'h24);
    chk("R7", "pushed pc lo", stk[8'hFE], 8'h01);

    // R3: NMI entry right after break, exact bus sequence
    run_cmd(3'd0, 16'hA000, 16'h0000, 1'b0, 1'b1, 8'h00);
    chk("R3", "bus count", tr_n, 7);
    chk("R11", "busy cycles", busy, 7);
    chk("R3", "addr0", tr_a[0], 16'hA000);
    chk("R3", "addr1", tr_a[1], 16'hA000);
    chk("R3", "addr2", tr_a[2], 16'h01FC);
    chk("R3", "addr3", tr_a[3], 16'h01FB);
    chk("R3", "addr4", tr_a[4], 16'h01FA);
    chk("R5", "addr5", tr_a[5], 16'hFFFA);
    chk("R5", "addr6", tr_a[6], 16'hFFFB);
    chk("R3", "write pattern", {tr_w[0], tr_w[1], tr_w[2], tr_w[3], tr_w[4], tr_w[5], tr_w[6]}, 7'b0011100);
    chk("R3", "data pc hi", tr_d[2], 8'hA0);
    chk("R3", "data pc lo", tr_d[3], 8'h00);
    chk("R3", "data status B clear", tr_d[4], 8'h24);
    chk("R3", "status", status_o, 8'h34);
    chk("R5", "pc", pc_o, 16'h9000);
    chk("R2", "sp", sp_o, 8'hF9);

    // R2: pop order and addresses
    run_cmd(3'd3, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'h00);
    chk("R2", "pop count", tr_n, 2);
    chk("R2", "pop addr0", tr_a[0], 16'h01FA);
    chk("R2", "pop addr1", tr_a[1], 16'h01FB);
    chk("R9", "pc", pc_o, 16'h0025);
    chk("R2", "sp", sp_o, 8'hFB);

    // R11: unused code has no effect
    run_cmd(3'd5, 16'h1234, 16'h5678, 1'b0, 1'b0, 8'h00);
    chk("R11", "bus count", tr_n, 0);
    chk("R11", "pc", pc_o, 16'h0025);
    chk("R11", "sp", sp_o, 8'hFB);
    chk("R11", "status", status_o, 8'h34);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule